// File: doc/BRIEF.md
# Inbound Address Translation Window

This block decodes one inbound memory window for a 32-bit bus target and maps hits onto the internal bus. Three registers set it up. The size mask decides how large the window is. The window base says where the window sits on the external bus. The translate value says where the window lands on the internal side. Address bits below the page boundary (bit 12 by default) are always offset bits and pass through translation unchanged.

The size mask does more than set a size. Each of its upper bits decides whether the matching bit of the window base can be written at all. A base bit whose mask bit is clear is held at zero. A fully cleared mask therefore pins the base at zero and closes the window.

The local processor reads and writes all three registers through a strobe port. The external configuration side has its own strobe port. From that port it can write the size mask and the window base, and it can read all three registers. A lookup address goes through a purely combinational path that produces a hit flag and the translated address in the same cycle.

Top module: `inbound_xlate_window`

## Requirements
- R1: After reset the size mask reads 0xFF000000, which gives a 16 MB window, and the window base and translate value read 0.
- R2: Bits 11:0 of the size mask always read 0, and writes to them from either port are ignored.
- R3: Bit n of the window base (n = 12..31) takes a written value only when bit n of the size mask is 1. Where the mask bit is 0, the base bit reads 0.
- R4: While the size mask is all zeros, base writes have no effect, the base reads 0, and no lookup address hits.
- R5: When the size mask is rewritten, every base bit whose new mask bit is 0 reads 0 from the next cycle on. In the same write, base bits whose mask bit stays 1 keep their value.
- R6: The hit flag is 1 exactly when the mask is non-zero and the lookup address equals the base on every bit where the mask is 1.
- R7: The translated address is (translate & mask) | (lookup & ~mask). It appears combinationally in the same cycle as the lookup address.
- R8: Bits 11:0 of the translate value read 0. Translate bits outside the mask do not affect the translated address.
- R9: Register select codes on both ports are 0 = size mask, 1 = window base, 2 = translate value, and 3 = none, which reads 0. A write to code 2 from the configuration port is ignored.
- R10: When both ports write the same register in one cycle, the local processor's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_we | input | 1 | Local processor write strobe |
| lp_sel | input | 2 | Local processor register select |
| lp_wdata | input | 32 | Local processor write data |
| lp_rdata | output | 32 | Local processor read data (combinational) |
| cfg_we | input | 1 | Configuration-side write strobe |
| cfg_sel | input | 2 | Configuration-side register select |
| cfg_wdata | input | 32 | Configuration-side write data |
| cfg_rdata | output | 32 | Configuration-side read data (combinational) |
| lookup_addr | input | 32 | External bus address to decode |
| win_hit | output | 1 | Lookup address falls inside the window |
| win_addr | output | 32 | Translated internal-bus address |

## Verification
The assertions assume that the write strobes are clean, known values once reset has been released. They also assume that a write which changes the size mask may coincide with a base write, which the register update handles. The bench drives strobes, selects and data only on the falling edge and reads only on the following falling edge, so every register update is settled before it is compared. The mask sweep covers every contiguous window size from 4 KB to 2 GB, plus one non-contiguous mask, and stays within these assumptions.

// File: rtl/xw_pkg.sv
package xw_pkg;
   typedef enum logic [1:0] {
      XW_SEL_MASK  = 2'd0,
      XW_SEL_BASE  = 2'd1,
      XW_SEL_XLATE = 2'd2,
      XW_SEL_NONE  = 2'd3
   } xw_sel_e;
endpackage

// File: rtl/xw_masked_reg.sv
// Register whose stored bits are ANDed with a keep mask each cycle.
module xw_masked_reg #(
   parameter int          W      = 32,
   parameter logic [W-1:0] RST   = '0,
   parameter bit          A_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_a,
   input  logic [W-1:0] wd_a,
   input  logic         we_b,
   input  logic [W-1:0] wd_b,
   input  logic [W-1:0] keep_mask,
   output logic [W-1:0] d_val,
   output logic [W-1:0] q_val
);
   logic [W-1:0] raw_d;

   generate
      if (A_WINS) begin : g_a_first
         always_comb begin
            if (we_a)      raw_d = wd_a;
            else if (we_b) raw_d = wd_b;
            else           raw_d = q_val;
         end
      end else begin : g_b_first
         always_comb begin
            if (we_b)      raw_d = wd_b;
            else if (we_a) raw_d = wd_a;
            else           raw_d = q_val;
         end
      end
   endgenerate

   assign d_val = raw_d & keep_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) q_val <= RST;
      else        q_val <= d_val;
   end

   // R3 / R5: no stored bit survives outside last cycle's keep mask
   assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_val & ~$past(keep_mask)) == '0));
endmodule

// File: rtl/xw_window_decode.sv
module xw_window_decode #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] size_mask,
   input  logic [W-1:0] win_base,
   input  logic [W-1:0] xlate_val,
   input  logic [W-1:0] addr,
   output logic         hit,
   output logic [W-1:0] xaddr
);
   logic open_win;

   assign open_win = |size_mask;
   assign hit      = open_win && (((addr ^ win_base) & size_mask) == '0);
   assign xaddr    = (xlate_val & size_mask) | (addr & ~size_mask);

   assert_closed_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (size_mask == '0) |-> !hit);
   assert_offset_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ((xaddr & ~size_mask) == (addr & ~size_mask)));
endmodule

// File: rtl/xw_read_mux.sv
module xw_read_mux #(
   parameter int W = 32
) (
   input  logic [1:0]   sel,
   input  logic [W-1:0] mask_q,
   input  logic [W-1:0] base_q,
   input  logic [W-1:0] xlate_q,
   output logic [W-1:0] rdata
);
   import xw_pkg::*;
   always_comb begin
      unique case (xw_sel_e'(sel))
         XW_SEL_MASK:  rdata = mask_q;
         XW_SEL_BASE:  rdata = base_q;
         XW_SEL_XLATE: rdata = xlate_q;
         default:      rdata = '0;
      endcase
   end
endmodule

// File: rtl/inbound_xlate_window.sv
module inbound_xlate_window #(
   parameter int ADDR_W     = 32,
   parameter int PAGE_LSB   = 12,
   parameter int MASK_RST_HI = 24,
   parameter bit LP_WINS    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_we,
   input  logic [1:0]        lp_sel,
   input  logic [ADDR_W-1:0] lp_wdata,
   output logic [ADDR_W-1:0] lp_rdata,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   input  logic [ADDR_W-1:0] lookup_addr,
   output logic              win_hit,
   output logic [ADDR_W-1:0] win_addr
);
   import xw_pkg::*;

   localparam logic [ADDR_W-1:0] PAGE_HI  = {ADDR_W{1'b1}} << PAGE_LSB;
   localparam logic [ADDR_W-1:0] MASK_RST = {ADDR_W{1'b1}} << MASK_RST_HI;

   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_width
         $error("inbound_xlate_window: ADDR_W out of range");
      end
      if (PAGE_LSB < 1 || PAGE_LSB >= ADDR_W) begin : g_bad_page
         $error("inbound_xlate_window: PAGE_LSB out of range");
      end
      if (MASK_RST_HI < PAGE_LSB || MASK_RST_HI > ADDR_W) begin : g_bad_rst
         $error("inbound_xlate_window: MASK_RST_HI out of range");
      end
   endgenerate

   logic mask_we_lp, mask_we_cfg, base_we_lp, base_we_cfg, xl_we_lp;
   logic [ADDR_W-1:0] mask_d, mask_q, base_d, base_q, xl_d, xl_q;

   assign mask_we_lp  = lp_we  && (lp_sel  == XW_SEL_MASK);
   assign mask_we_cfg = cfg_we && (cfg_sel == XW_SEL_MASK);
   assign base_we_lp  = lp_we  && (lp_sel  == XW_SEL_BASE);
   assign base_we_cfg = cfg_we && (cfg_sel == XW_SEL_BASE);
   assign xl_we_lp    = lp_we  && (lp_sel  == XW_SEL_XLATE);

   xw_masked_reg #(.W(ADDR_W), .RST(MASK_RST), .A_WINS(LP_WINS)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .we_a(mask_we_lp), .wd_a(lp_wdata),
      .we_b(mask_we_cfg), .wd_b(cfg_wdata),
      .keep_mask(PAGE_HI), .d_val(mask_d), .q_val(mask_q));

   // base bits are kept only where the incoming mask allows them
   xw_masked_reg #(.W(ADDR_W), .RST('0), .A_WINS(LP_WINS)) u_base (
      .clk(clk), .rst_n(rst_n),
      .we_a(base_we_lp), .wd_a(lp_wdata),
      .we_b(base_we_cfg), .wd_b(cfg_wdata),
      .keep_mask(mask_d), .d_val(base_d), .q_val(base_q));

   xw_masked_reg #(.W(ADDR_W), .RST('0), .A_WINS(1'b1)) u_xlate (
      .clk(clk), .rst_n(rst_n),
      .we_a(xl_we_lp), .wd_a(lp_wdata),
      .we_b(1'b0), .wd_b('0),
      .keep_mask(PAGE_HI), .d_val(xl_d), .q_val(xl_q));

   xw_window_decode #(.W(ADDR_W)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .size_mask(mask_q), .win_base(base_q), .xlate_val(xl_q),
      .addr(lookup_addr), .hit(win_hit), .xaddr(win_addr));

   xw_read_mux #(.W(ADDR_W)) u_lp_rd (
      .sel(lp_sel), .mask_q(mask_q), .base_q(base_q), .xlate_q(xl_q),
      .rdata(lp_rdata));

   xw_read_mux #(.W(ADDR_W)) u_cfg_rd (
      .sel(cfg_sel), .mask_q(mask_q), .base_q(base_q), .xlate_q(xl_q),
      .rdata(cfg_rdata));

   assert_mask_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q & ~PAGE_HI) == '0);
   assert_base_within_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (base_q & ~mask_q) == '0);
   assert_xlate_low_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_q & ~PAGE_HI) == '0);
   assert_cfg_no_xlate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_we_lp |=> $stable(xl_q));
   assert_lp_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we_lp && mask_we_cfg && LP_WINS) |=> (mask_q == ($past(lp_wdata) & PAGE_HI)));
endmodule

// File: tb/inbound_xlate_window_bench.sv
module inbound_xlate_window_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lp_we = 1'b0, cfg_we = 1'b0;
   logic [1:0]  lp_sel = 2'd3, cfg_sel = 2'd3;
   logic [31:0] lp_wdata = '0, cfg_wdata = '0, lookup_addr = '0;
   logic [31:0] lp_rdata, cfg_rdata, win_addr;
   logic        win_hit;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic [31:0] lfsr = 32'h1D872B41;

   always #10 clk = ~clk;

   inbound_xlate_window u_inbound_xlate_window (
      .clk(clk), .rst_n(rst_n),
      .lp_we(lp_we), .lp_sel(lp_sel), .lp_wdata(lp_wdata), .lp_rdata(lp_rdata),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .lookup_addr(lookup_addr), .win_hit(win_hit), .win_addr(win_addr));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic step();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
   endtask

   task automatic lp_wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk); lp_we = 1'b1; lp_sel = s; lp_wdata = d;
      @(negedge clk); lp_we = 1'b0; lp_sel = 2'd3;
   endtask

   task automatic cfg_wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0; cfg_sel = 2'd3;
   endtask

   task automatic lp_rd(input logic [1:0] s, output logic [31:0] v);
      lp_sel = s; #1; v = lp_rdata; lp_sel = 2'd3;
   endtask

   task automatic cfg_rd(input logic [1:0] s, output logic [31:0] v);
      cfg_sel = s; #1; v = cfg_rdata; cfg_sel = 2'd3;
   endtask

   task automatic probe(input logic [31:0] a, input logic [31:0] m, input logic [31:0] b,
                        input logic [31:0] x, input string tag);
      lookup_addr = a; #1;
      check({tag, " R6 hit"}, {31'd0, win_hit}, {31'd0, (m != 0) && (((a ^ b) & m) == 0)});
      check({tag, " R7 xaddr"}, win_addr, (x & m) | (a & ~m));
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, m, x;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      lp_rd(2'd0, v); check("R1 mask", v, 32'hFF000000);
      lp_rd(2'd1, v); check("R1 base", v, 32'h0);
      lp_rd(2'd2, v); check("R1 xlate", v, 32'h0);
      // R2 low mask bits
      lp_wr(2'd0, 32'hFFFFFFFF); lp_rd(2'd0, v); check("R2 lp mask", v, 32'hFFFFF000);
      cfg_wr(2'd0, 32'h00000FFF); cfg_rd(2'd0, v); check("R2 cfg mask", v, 32'h0);
      // R4 closed window
      cfg_wr(2'd1, 32'hFFFFFFFF); lp_wr(2'd1, 32'h12345678);
      cfg_rd(2'd1, v); check("R4 base locked", v, 32'h0);
      for (int i = 0; i < 8; i++) begin
         step(); lookup_addr = lfsr; #1;
         check("R4 no hit", {31'd0, win_hit}, 32'd0);
      end
      // R8 / R9 translate value
      lp_wr(2'd2, 32'hA5A5A5A5); lp_rd(2'd2, v); check("R8 xlate low", v, 32'hA5A5A000);
      cfg_wr(2'd2, 32'h11111111); cfg_rd(2'd2, v); check("R9 cfg xlate ignored", v, 32'hA5A5A000);
      cfg_rd(2'd3, v); check("R9 none reads zero", v, 32'h0);
      x = 32'hA5A5A000;
      // R3 R6 R7 sweep over every contiguous window size
      for (int k = 12; k < 32; k++) begin
         m = 32'hFFFFFFFF << k;
         cfg_wr(2'd0, m);
         cfg_wr(2'd1, 32'hFFFFFFFF);
         cfg_rd(2'd1, v); check($sformatf("R3 base k=%0d", k), v, m);
         step(); cfg_wr(2'd1, lfsr); cfg_rd(2'd1, v);
         check($sformatf("R3 base rnd k=%0d", k), v, lfsr & m);
         for (int j = 0; j < 4; j++) begin
            step();
            probe((v & m) | (lfsr & ~m), m, v, x, $sformatf("in k=%0d", k));
            probe(((v & m) | (lfsr & ~m)) ^ (32'h1 << k), m, v, x, $sformatf("out k=%0d", k));
         end
      end
      // R3 non-contiguous mask
      cfg_wr(2'd0, 32'hF0F0F000); cfg_wr(2'd1, 32'hFFFFFFFF);
      cfg_rd(2'd1, v); check("R3 sparse", v, 32'hF0F0F000);
      probe(32'hF5F6F123, 32'hF0F0F000, 32'hF0F0F000, x, "R3 sparse");
      // R8 translate bits outside mask ignored
      lp_wr(2'd0, 32'hFFF00000); lp_wr(2'd1, 32'hABC00000); lp_wr(2'd2, 32'hFFFFFFFF);
      lookup_addr = 32'hABC12345; #1;
      check("R8 xlate outside mask", win_addr, 32'hFFF12345);
      check("R6 hit R8 case", {31'd0, win_hit}, 32'd1);
      // R5 shrink clears base bits
      lp_wr(2'd0, 32'hFFFFF000); lp_wr(2'd1, 32'h12345000);
      cfg_wr(2'd0, 32'hFFFF0000); lp_rd(2'd1, v); check("R5 shrink", v, 32'h12340000);
      cfg_wr(2'd0, 32'hFFFFF000); lp_rd(2'd1, v); check("R5 no regrow", v, 32'h12340000);
      // R10 simultaneous writes
      @(negedge clk);
      lp_we = 1'b1; lp_sel = 2'd0; lp_wdata = 32'hFFFF8000;
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'hF0000000;
      @(negedge clk);
      lp_we = 1'b0; cfg_we = 1'b0; lp_sel = 2'd3; cfg_sel = 2'd3;
      lp_rd(2'd0, v); check("R10 lp wins", v, 32'hFFFF8000);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule